// File: doc/BRIEF.md
# Displacement-Addressed Load/Store Unit

This unit executes six move instructions that transfer data between a sixteen-entry, 32-bit register file and a byte-addressed data memory. Each instruction names a base register and a 4-bit unsigned displacement. The displacement is scaled by the access size: one for bytes, two for 16-bit words and four for 32-bit longwords. Stores take their data from R0 for byte and word sizes, or from any register for longwords. Loads deliver a byte or word into R0 after sign extension, or a longword into any register. Memory is big-endian.

The unit accepts one instruction per cycle through a valid/ready pair. In the cycle after acceptance it places a registered request on a synchronous memory port. Read data returns one cycle after that request and is written to the register file at the end of that cycle. A load whose destination is R0 makes the next instruction wait one cycle if that instruction reads R0. In the following cycle the returning value is forwarded to the waiting instruction. An instruction outside the six encodings does nothing except pulse an illegal flag.

Top module: `disp_lsu`

## Requirements
- R1: The unit accepts only these encodings: 0x80nd store byte R0, 0x81nd store word R0, 0x1nmd store long Rm, 0x84md load byte, 0x85md load word, 0x5nmd load long. Here n is bits 11:8 or 7:4 as shown and d is bits 3:0. Any other word produces no memory request and sets `illegal` high for the one cycle after acceptance.
- R2: The effective address is the base register plus the zero-extended displacement times 1, 2 or 4 for byte, word or longword. The base is Rn for stores and Rm for loads. The largest offsets are therefore 15, 30 and 60.
- R3: A store drives `mem_be[i]` for bits 8i+7:8i, and lane 0 (bits 31:24, `mem_be[3]`) holds the lowest address. A byte store enables `4'b1000 >> addr[1:0]`. A word store enables 1100 when addr[1] is 0 and 0011 otherwise. A longword store enables 1111. Byte and word data are replicated across all lanes.
- R4: The request for an accepted instruction appears on the port in the next cycle and lasts exactly one cycle. `mem_we` marks a store and `mem_re` marks a load, and the two are never high together. A load drives `mem_be` as 0.
- R5: A load takes its byte or word from the big-endian lane that the low address bits select and sign-extends it to 32 bits. A longword is taken unchanged.
- R6: Byte and word loads write R0, and longword loads write Rn. The write happens at the clock edge that ends the cycle in which `mem_rdata` is valid.
- R7: When the instruction in the memory cycle is a load into R0, a presented instruction that reads R0 is held with `instr_ready` low for exactly one cycle. An instruction that does not read R0 is accepted at once.
- R8: A register value that is being written back in the current cycle is forwarded to the instruction issuing in that cycle.
- R9: Reset clears all registers to zero, clears all memory strobes and `illegal`, and drives `instr_ready` high.
- R10: Without a stall, instructions issue back to back, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | An instruction word is presented |
| instr | input | 16 | Instruction word |
| instr_ready | output | 1 | Presented instruction is accepted this cycle |
| mem_addr | output | 32 | Byte address of the memory request |
| mem_wdata | output | 32 | Store data, lane-replicated |
| mem_be | output | 4 | Byte enables for stores, bit 3 is the most significant lane |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_rdata | input | 32 | Read data, valid one cycle after `mem_re` |
| illegal | output | 1 | One-cycle flag for an unrecognised instruction |

## Verification
The embedded assertions check the following on every cycle: the shape of the store byte enables, that the two strobes are exclusive, that a load drives no enables, and that an illegal flag never coincides with a request. They also check that a stall lasts one cycle and only happens while a load is in flight, that loaded bytes are sign-extended, and that an address offset never exceeds 60. Only the bench's scenarios can show that the right register value reaches the port and that addresses scale correctly at the maximum displacements. They also show that each big-endian lane is picked correctly on a load, that a dependent instruction gets the forwarded value after its one-cycle wait, and that an independent instruction behind a load issues without delay.

// File: rtl/dlsu_pkg.sv
// Shared constants and types for the displacement load/store unit.
// Assumes a 32-bit datapath with byte lanes and a 16-bit instruction word.
package dlsu_pkg;

    localparam int XLEN   = 32;
    localparam int NREG   = 16;
    localparam int RIDX_W = $clog2(NREG);
    localparam int DISP_W = 4;
    localparam int BE_W   = XLEN / 8;
    localparam int LANE_W = $clog2(BE_W);
    localparam int IW     = 16;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } acc_size_t;

    typedef struct packed {
        logic                 legal;
        logic                 is_load;
        logic                 is_store;
        acc_size_t            size;
        logic [RIDX_W-1:0]    base_idx;
        logic [RIDX_W-1:0]    data_idx;
        logic [RIDX_W-1:0]    dest_idx;
        logic [DISP_W-1:0]    disp;
        logic                 reads_r0;
    } dec_t;

endpackage

// File: rtl/dlsu_decode.sv
// Instruction decoder: maps a 16-bit word onto one of the six move forms.
// Assumes that unknown words become non-legal no-ops. Purely combinational.
module dlsu_decode
    import dlsu_pkg::*;
(
    input  logic [IW-1:0] instr,
    output dec_t          dec
);

    // Field extraction and form selection.
    always_comb begin
        dec          = '0;
        dec.size     = SZ_BYTE;
        dec.disp     = instr[DISP_W-1:0];
        dec.base_idx = instr[7:4];
        casez (instr[15:8])
            8'b1000_0000: begin
                dec.legal    = 1'b1;
                dec.is_store = 1'b1;
                dec.size     = SZ_BYTE;
            end
            8'b1000_0001: begin
                dec.legal    = 1'b1;
                dec.is_store = 1'b1;
                dec.size     = SZ_WORD;
            end
            8'b0001_????: begin
                dec.legal    = 1'b1;
                dec.is_store = 1'b1;
                dec.size     = SZ_LONG;
                dec.base_idx = instr[11:8];
                dec.data_idx = instr[7:4];
            end
            8'b1000_0100: begin
                dec.legal    = 1'b1;
                dec.is_load  = 1'b1;
                dec.size     = SZ_BYTE;
            end
            8'b1000_0101: begin
                dec.legal    = 1'b1;
                dec.is_load  = 1'b1;
                dec.size     = SZ_WORD;
            end
            8'b0101_????: begin
                dec.legal    = 1'b1;
                dec.is_load  = 1'b1;
                dec.size     = SZ_LONG;
                dec.dest_idx = instr[11:8];
            end
            default: begin
                dec.base_idx = '0;
            end
        endcase
        dec.reads_r0 = dec.legal &&
                       ((dec.base_idx == '0) || (dec.is_store && dec.data_idx == '0));
    end

endmodule

// File: rtl/dlsu_regfile.sv
// Register file with two read ports, one write port and write-to-read bypass.
// Assumes that a write presented this cycle is visible to reads in the same cycle.
module dlsu_regfile #(
    parameter int NREG = 16,
    parameter int DW   = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(NREG)-1:0] rd_a_idx,
    output logic [DW-1:0]           rd_a_data,
    input  logic [$clog2(NREG)-1:0] rd_b_idx,
    output logic [DW-1:0]           rd_b_data,
    input  logic                    wr_en,
    input  logic [$clog2(NREG)-1:0] wr_idx,
    input  logic [DW-1:0]           wr_data
);

    logic [DW-1:0] regs [NREG];

    // Storage update: clear on reset, otherwise write one entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (wr_en) begin
            regs[wr_idx] <= wr_data;
        end
    end

    // Read ports with forwarding of the value being written back.
    always_comb begin
        rd_a_data = (wr_en && wr_idx == rd_a_idx) ? wr_data : regs[rd_a_idx];
        rd_b_data = (wr_en && wr_idx == rd_b_idx) ? wr_data : regs[rd_b_idx];
    end

endmodule

// File: rtl/dlsu_agu.sv
// Address generator and store formatter: scales the displacement, adds the base,
// and builds big-endian byte enables and lane-replicated store data.
// Assumes that misaligned low address bits are ignored within the access size.
module dlsu_agu
    import dlsu_pkg::*;
#(
    parameter int DW     = 32,
    parameter int DISP_B = 4
) (
    input  logic [DW-1:0]     base,
    input  logic [DISP_B-1:0] disp,
    input  acc_size_t         size,
    input  logic [DW-1:0]     st_data,
    output logic [DW-1:0]     addr,
    output logic [DW/8-1:0]   be,
    output logic [DW-1:0]     wdata
);

    localparam int NB   = DW / 8;
    localparam int LW   = $clog2(NB);
    localparam logic [DW-1:0] MAX_OFF = DW'((1 << DISP_B) - 1) << 2;

    logic [DW-1:0] offset;
    logic [NB-1:0] mask;
    logic [LW-1:0] lane;

    // Effective address and lane formatting.
    always_comb begin
        offset = DW'(disp) << size;
        addr   = base + offset;
        case (size)
            SZ_BYTE: begin
                mask  = {1'b1, {(NB-1){1'b0}}};
                lane  = addr[LW-1:0];
                wdata = {NB{st_data[7:0]}};
            end
            SZ_WORD: begin
                mask  = {2'b11, {(NB-2){1'b0}}};
                lane  = addr[LW-1:0] & ~LW'(1);
                wdata = {(NB/2){st_data[15:0]}};
            end
            default: begin
                mask  = '1;
                lane  = '0;
                wdata = st_data;
            end
        endcase
        be = mask >> lane;
    end

    // Offset never exceeds the longword reach (R2).
    always_comb begin
        a_r2_offset_reach: assert ((addr - base) <= MAX_OFF);
    end

endmodule

// File: rtl/dlsu_ldalign.sv
// Load formatter: picks the big-endian lane of a returned word and sign-extends
// bytes and words to the full width. Purely combinational.
module dlsu_ldalign
    import dlsu_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0]           rdata,
    input  logic [$clog2(DW/8)-1:0] lane,
    input  acc_size_t               size,
    output logic [DW-1:0]           result
);

    localparam int LW = $clog2(DW / 8);

    logic [DW-1:0] shifted;
    logic [LW-1:0] lane_eff;

    // Lane selection by shifting the wanted bytes to the top, then extension.
    always_comb begin
        lane_eff = (size == SZ_WORD) ? (lane & ~LW'(1)) : lane;
        shifted  = rdata << {lane_eff, 3'b000};
        case (size)
            SZ_BYTE: result = {{(DW-8){shifted[DW-1]}}, shifted[DW-1 -: 8]};
            SZ_WORD: result = {{(DW-16){shifted[DW-1]}}, shifted[DW-1 -: 16]};
            default: result = rdata;
        endcase
    end

    // Byte results carry copies of the byte's sign bit above it (R5).
    always_comb begin
        if (size == SZ_BYTE) begin
            a_r5_byte_sext: assert (result[DW-1:8] == {(DW-8){result[7]}});
        end
    end

endmodule

// File: rtl/disp_lsu.sv
// Displacement load/store unit top: decode and issue in cycle 0, registered
// memory request in cycle 1, read data and register write in cycle 2.
// Assumes a synchronous memory that returns read data one cycle after mem_re.
// Only R0 is interlocked against an in-flight load.
module disp_lsu
    import dlsu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_valid,
    input  logic [IW-1:0]   instr,
    output logic            instr_ready,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    output logic [BE_W-1:0] mem_be,
    output logic            mem_we,
    output logic            mem_re,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            illegal
);

    dec_t              dec;
    logic [XLEN-1:0]   base_val;
    logic [XLEN-1:0]   data_val;
    logic [XLEN-1:0]   agu_addr;
    logic [BE_W-1:0]   agu_be;
    logic [XLEN-1:0]   agu_wdata;
    logic              hazard;
    logic              accept;
    logic              do_store;
    logic              do_load;
    logic [RIDX_W-1:0] m_dest;
    acc_size_t         m_size;
    logic              w_valid;
    logic [RIDX_W-1:0] w_dest;
    acc_size_t         w_size;
    logic [LANE_W-1:0] w_lane;
    logic [XLEN-1:0]   wb_data;

    dlsu_decode u_decode (
        .instr (instr),
        .dec   (dec)
    );

    dlsu_regfile #(.NREG(NREG), .DW(XLEN)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_idx  (dec.base_idx),
        .rd_a_data (base_val),
        .rd_b_idx  (dec.data_idx),
        .rd_b_data (data_val),
        .wr_en     (w_valid),
        .wr_idx    (w_dest),
        .wr_data   (wb_data)
    );

    dlsu_agu #(.DW(XLEN), .DISP_B(DISP_W)) u_agu (
        .base    (base_val),
        .disp    (dec.disp),
        .size    (dec.size),
        .st_data (data_val),
        .addr    (agu_addr),
        .be      (agu_be),
        .wdata   (agu_wdata)
    );

    dlsu_ldalign #(.DW(XLEN)) u_align (
        .rdata  (mem_rdata),
        .lane   (w_lane),
        .size   (w_size),
        .result (wb_data)
    );

    // Interlock: hold an R0 reader while an R0 load sits in the memory cycle.
    always_comb begin
        hazard      = instr_valid && mem_re && (m_dest == '0) && dec.reads_r0;
        instr_ready = !hazard;
        accept      = instr_valid && instr_ready;
        do_store    = accept && dec.legal && dec.is_store;
        do_load     = accept && dec.legal && dec.is_load;
    end

    // Memory-cycle registers: drive the request port and the illegal flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr  <= '0;
            mem_wdata <= '0;
            mem_be    <= '0;
            mem_we    <= 1'b0;
            mem_re    <= 1'b0;
            illegal   <= 1'b0;
            m_dest    <= '0;
            m_size    <= SZ_BYTE;
        end else begin
            mem_addr  <= agu_addr;
            mem_wdata <= agu_wdata;
            mem_be    <= do_store ? agu_be : '0;
            mem_we    <= do_store;
            mem_re    <= do_load;
            illegal   <= accept && !dec.legal;
            m_dest    <= dec.dest_idx;
            m_size    <= dec.size;
        end
    end

    // Write-back registers: track the load whose data returns this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_valid <= 1'b0;
            w_dest  <= '0;
            w_size  <= SZ_BYTE;
            w_lane  <= '0;
        end else begin
            w_valid <= mem_re;
            w_dest  <= m_dest;
            w_size  <= m_size;
            w_lane  <= mem_addr[LANE_W-1:0];
        end
    end

    // R4: strobes are exclusive.
    a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R4: loads drive no byte enables.
    a_r4_load_no_be: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> (mem_be == '0));

    // R3: store enables form one lane, an aligned half, or the whole word.
    a_r3_be_shape: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($countones(mem_be) == 1 || mem_be == 4'b1100 ||
                    mem_be == 4'b0011 || mem_be == 4'b1111));

    // R1: an illegal word never produces a request.
    a_r1_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!mem_we && !mem_re));

    // R7: a stall only happens while a load occupies the memory cycle.
    a_r7_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_ready |-> mem_re);

    // R7: a stall lasts a single cycle.
    a_r7_stall_once: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_ready |=> instr_ready);

endmodule

// File: tb/disp_lsu_tb.sv
module disp_lsu_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = '0;
    logic        instr_ready;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_we;
    logic        mem_re;
    logic [31:0] mem_rdata;
    logic        illegal;

    int n_chk = 0;
    int n_bad = 0;
    int stalls = 0;

    always #4 clk = ~clk;

    disp_lsu u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .instr       (instr),
        .instr_ready (instr_ready),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_be      (mem_be),
        .mem_we      (mem_we),
        .mem_re      (mem_re),
        .mem_rdata   (mem_rdata),
        .illegal     (illegal)
    );

    // Big-endian memory model, word-indexed, preloaded during reset.
    logic [31:0] mem [256];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= '0;
            mem[1]  <= 32'h0000_0100;
            mem[2]  <= 32'h0000_0080;
            mem[3]  <= 32'h8123_45F6;
            mem[4]  <= 32'h0000_0041;
            mem[5]  <= 32'h1234_56C7;
            mem[33] <= 32'h7F80_1234;
            mem[34] <= 32'h0000_9ABC;
            mem[79] <= 32'hCAFE_F00D;
            mem_rdata <= '0;
        end else begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end
            if (mem_re) mem_rdata <= mem[mem_addr[9:2]];
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Present one instruction, wait for acceptance, return in the request cycle.
    task automatic issue(input logic [15:0] w);
        @(negedge clk);
        instr_valid = 1'b1;
        instr = w;
        stalls = 0;
        #1;
        while (!instr_ready) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        instr_valid = 1'b0;
        #1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Store R0 as a longword at R1+0 and compare the data (R6 write target).
    task automatic show_r0(input string req, input logic [31:0] exp);
        issue(16'h1100);
        check(req, mem_wdata, exp);
        idle(2);
    endtask

    // Vector: instr, addr, be, we, re, wdata, illegal
    localparam int NV = 13;
    localparam logic [86:0] VEC [NV] = '{
        {16'h1130, 32'h0000_0100, 4'b1111, 1'b1, 1'b0, 32'h8123_45F6, 1'b0},
        {16'h123F, 32'h0000_00BC, 4'b1111, 1'b1, 1'b0, 32'h8123_45F6, 1'b0},
        {16'h801F, 32'h0000_010F, 4'b0001, 1'b1, 1'b0, 32'hC7C7_C7C7, 1'b0},
        {16'h8014, 32'h0000_0104, 4'b1000, 1'b1, 1'b0, 32'hC7C7_C7C7, 1'b0},
        {16'h8015, 32'h0000_0105, 4'b0100, 1'b1, 1'b0, 32'hC7C7_C7C7, 1'b0},
        {16'h8115, 32'h0000_010A, 4'b0011, 1'b1, 1'b0, 32'h56C7_56C7, 1'b0},
        {16'h812F, 32'h0000_009E, 4'b0011, 1'b1, 1'b0, 32'h56C7_56C7, 1'b0},
        {16'h8112, 32'h0000_0104, 4'b1100, 1'b1, 1'b0, 32'h56C7_56C7, 1'b0},
        {16'h1112, 32'h0000_0108, 4'b1111, 1'b1, 1'b0, 32'h0000_0100, 1'b0},
        {16'h551F, 32'h0000_013C, 4'b0000, 1'b0, 1'b1, 32'h0000_0000, 1'b0},
        {16'h8200, 32'h0000_0000, 4'b0000, 1'b0, 1'b0, 32'h0000_0000, 1'b1},
        {16'hFFFF, 32'h0000_0000, 4'b0000, 1'b0, 1'b0, 32'h0000_0000, 1'b1},
        {16'h6123, 32'h0000_0000, 4'b0000, 1'b0, 1'b0, 32'h0000_0000, 1'b1}
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin : main
        // R9: reset state
        repeat (3) @(negedge clk);
        #1;
        check("R9 mem_we in reset", {31'd0, mem_we}, 32'd0);
        check("R9 mem_re in reset", {31'd0, mem_re}, 32'd0);
        check("R9 illegal in reset", {31'd0, illegal}, 32'd0);
        check("R9 ready in reset", {31'd0, instr_ready}, 32'd1);
        @(negedge clk);
        rst_n = 1'b1;
        idle(1);

        // R9: registers read as zero after reset (store R7 at R0+0)
        issue(16'h1070);
        check("R9 cleared register data", mem_wdata, 32'd0);
        check("R9 zero base address", mem_addr, 32'd0);
        idle(2);

        // R6: longword loads fill R1..R4, then R0
        issue(16'h5101); idle(3);
        issue(16'h5202); idle(3);
        issue(16'h5303); idle(3);
        issue(16'h5404); idle(3);
        issue(16'h5005); idle(3);

        // R1 R2 R3 R4: table of stores, a load and illegal words
        for (int v = 0; v < NV; v++) begin
            logic [15:0] w;
            logic [31:0] ea, ed;
            logic [3:0]  eb;
            logic        ewe, ere, eil;
            {w, ea, eb, ewe, ere, ed, eil} = VEC[v];
            issue(w);
            check("R4 write strobe", {31'd0, mem_we}, {31'd0, ewe});
            check("R4 read strobe", {31'd0, mem_re}, {31'd0, ere});
            check("R1 illegal flag", {31'd0, illegal}, {31'd0, eil});
            if (ewe || ere) check("R2 effective address", mem_addr, ea);
            if (ewe || ere) check("R3 byte enables", {28'd0, mem_be}, {28'd0, eb});
            if (ewe) check("R3 store data", mem_wdata, ed);
            @(negedge clk);
            #1;
            check("R1 illegal lasts one cycle", {31'd0, illegal}, 32'd0);
            check("R4 request lasts one cycle", {30'd0, mem_we, mem_re}, 32'd0);
            idle(2);
        end

        // R6: longword load into R5 (from 0x13C) appears unchanged
        issue(16'h1150);
        check("R6 longword load into Rn", mem_wdata, 32'hCAFE_F00D);
        idle(2);

        // R5: lane selection and sign extension
        issue(16'h8424); idle(2); show_r0("R5 byte lane0 positive", 32'h0000_007F);
        issue(16'h8425); idle(2); show_r0("R5 byte lane1 negative", 32'hFFFF_FF80);
        issue(16'h8427); idle(2); show_r0("R5 byte lane3", 32'h0000_0034);
        issue(16'h8522); idle(2); show_r0("R5 word upper half", 32'h0000_7F80);
        issue(16'h8523); idle(2); show_r0("R5 word lower half", 32'h0000_1234);
        issue(16'h8525); idle(2); show_r0("R5 word negative", 32'hFFFF_9ABC);

        // R8: load then one gap, then use: no stall, forwarded value
        issue(16'h8424);
        issue(16'h1100);
        check("R8 no stall after one gap", stalls, 0);
        check("R8 forwarded data", mem_wdata, 32'h0000_007F);
        idle(2);

        // R7 R8: back-to-back R0 reader is held exactly one cycle
        @(negedge clk);
        instr_valid = 1'b1;
        instr = 16'h8425;
        @(posedge clk);
        @(negedge clk);
        instr = 16'h1100;
        #1;
        check("R7 ready low behind R0 load", {31'd0, instr_ready}, 32'd0);
        @(negedge clk);
        #1;
        check("R7 ready back after one cycle", {31'd0, instr_ready}, 32'd1);
        @(posedge clk);
        @(negedge clk);
        instr_valid = 1'b0;
        #1;
        check("R8 stalled store issues", {31'd0, mem_we}, 32'd1);
        check("R8 stalled store gets loaded value", mem_wdata, 32'hFFFF_FF80);
        idle(2);

        // R7 R10: independent instruction behind an R0 load issues at once
        @(negedge clk);
        instr_valid = 1'b1;
        instr = 16'h8424;
        @(posedge clk);
        @(negedge clk);
        instr = 16'h1132;
        #1;
        check("R7 independent not held", {31'd0, instr_ready}, 32'd1);
        check("R10 load request in its cycle", {31'd0, mem_re}, 32'd1);
        @(posedge clk);
        @(negedge clk);
        instr_valid = 1'b0;
        #1;
        check("R10 back-to-back store issued", {31'd0, mem_we}, 32'd1);
        check("R10 back-to-back address", mem_addr, 32'h0000_0108);
        check("R10 back-to-back data", mem_wdata, 32'h8123_45F6);
        idle(2);
        show_r0("R6 byte load wrote R0", 32'h0000_007F);

        // R9: reset in mid-run clears registers
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        issue(16'h1130);
        check("R9 register cleared by reset", mem_wdata, 32'd0);
        check("R9 base cleared by reset", mem_addr, 32'd0);
        idle(2);

        summary();
        $finish;
    end

endmodule